// File: doc/BRIEF.md
# Modulo Counter Timer

A 16-bit up-counting timer on a 32-bit register port, meant to serve as a periodic or one-shot event source or as a free-running time base. A power-of-two prescaler divides the system clock before it reaches the counter. The counter climbs from a programmable start value to a programmable end value. On the next tick it reloads the start value and raises a sticky overflow flag. The level interrupt follows that flag when it is enabled.

The end value (MOD) and the start value (CNTIN) are double-buffered. A write lands in a shadow copy, and that copy moves into the active register only while the counter is stopped. Any write to the count register throws away its data and reloads CNTIN. To program a delay of N ticks, software writes N − 1 to MOD with CNTIN at 0. A static strap input selects big-endian byte order for every access on the port.

Top module: `wrap_timer`

## Requirements
- R1: After reset every register reads 0, the counter is stopped and `irq_o` is low.
- R2: The registers sit at byte offsets 0x00 (control), 0x04 (count), 0x08 (MOD) and 0x4C (CNTIN). The control word holds prescaler exponent PS in bits [2:0], clock select in bits [4:3], interrupt enable in bit 6 and overflow flag in bit 7. Bit 5 and any unmapped offset read 0. Read data appears on `rdata_o` one clock after the cycle in which `rd_en_i` is high.
- R3: While running, the counter advances once every 2^PS system clocks, for PS from 0 to 7.
- R4: On a tick with count equal to MOD, the counter loads CNTIN. Otherwise it increments, so one period is MOD − CNTIN + 1 ticks.
- R5: The overflow flag is set on the tick that reloads CNTIN. A control write with bit 7 at 0 clears it. Writing 1 to bit 7 leaves it unchanged.
- R6: `irq_o` is high exactly while the overflow flag and the interrupt enable are both 1.
- R7: A write of any value to the count register loads the counter with the active CNTIN.
- R8: MOD and CNTIN writes go to a shadow copy that is transferred only while the counter is stopped. A write made while running stays pending until the next stop. Reads return the active value.
- R9: Clock select 01 runs the counter. Values 00, 10 and 11 stop it, and the count is held.
- R10: The prescaler divider restarts from zero whenever clock select leaves 01, so no partial prescale interval is carried into the next run.
- R11: With `big_endian_i` high, write data is taken and read data is returned in byte-swapped order (byte 0 on bits [31:24]). With it low, no swap is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| big_endian_i | input | 1 | Static byte-order strap |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Overflow interrupt, level high |

## Verification
The assertions rely on a few conditions holding at the inputs. The strap must not change while an access is in flight. MOD and CNTIN should change only at the stop boundary, and the count should stay still while the clock is gated, except when the count register is written. The stimulus changes the strap only between accesses, with the port idle. It leaves at least one idle cycle between accesses, so a shadow write has reached the active register before the next access depends on it. Run lengths are counted in whole clocks from the starting control write to the stopping one, so the expected tick count is the run length shifted right by PS.

// File: rtl/wrap_timer_pkg.sv
package wrap_timer_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;
  localparam int PS_W   = 3;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_MOD  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_INIT = 8'h4C;

  typedef enum logic [1:0] {
    CLK_OFF  = 2'b00,
    CLK_SYS  = 2'b01,
    CLK_RSV2 = 2'b10,
    CLK_RSV3 = 2'b11
  } clk_sel_e;

  function automatic logic [REG_W-1:0] byte_swap(input logic [REG_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/wrap_timer_presc.sv
module wrap_timer_presc
  import wrap_timer_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            tick_o
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask   = ~({DIV_W{1'b1}} << ps_i);
  assign tick_o = run_i && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (!run_i) div_q <= '0;  // restart on every stop
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/wrap_timer_core.sv
module wrap_timer_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             cnt_wr_i,
  input  logic             mod_wr_i,
  input  logic             init_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] mod_o,
  output logic [CNT_W-1:0] init_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, mod_q, init_q, mod_buf_q, init_buf_q;

  assign wrap_o = tick_i && !cnt_wr_i && (cnt_q == mod_q);
  assign cnt_o  = cnt_q;
  assign mod_o  = mod_q;
  assign init_o = init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_buf_q  <= '0;
      init_buf_q <= '0;
    end else begin
      if (mod_wr_i)  mod_buf_q  <= wdata_i;
      if (init_wr_i) init_buf_q <= wdata_i;
    end
  end

  // shadow transfer only while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q  <= '0;
      init_q <= '0;
    end else if (!run_i) begin
      mod_q  <= mod_buf_q;
      init_q <= init_buf_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_wr_i) cnt_q <= init_q;
    else if (wrap_o)   cnt_q <= init_q;
    else if (tick_i)   cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_running_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> run_i);
  assert_wrap_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_q == $past(init_q));
  assert_cnt_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> cnt_q == $past(init_q));
  assert_shadow_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> ($stable(mod_q) && $stable(init_q)));
  assert_hold_stopped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wrap_timer_regs.sv
module wrap_timer_regs
  import wrap_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  mod_i,
  input  logic [CNT_W-1:0]  init_i,
  input  logic              wrap_i,
  output logic [PS_W-1:0]   ps_o,
  output clk_sel_e          clks_o,
  output logic              toie_o,
  output logic              tof_o,
  output logic              cnt_wr_o,
  output logic              mod_wr_o,
  output logic              init_wr_o,
  output logic [REG_W-1:0]  rdata_o
);
  localparam int PAD_W = REG_W - CNT_W;

  logic              ctrl_wr;
  logic [PS_W-1:0]   ps_q;
  clk_sel_e          clks_q;
  logic              toie_q, tof_q;
  logic [REG_W-1:0]  rd_mux, rdata_q;
  logic              unused_ok;

  assign ctrl_wr   = wr_en_i && (addr_i == OFF_CTRL);
  assign cnt_wr_o  = wr_en_i && (addr_i == OFF_CNT);
  assign mod_wr_o  = wr_en_i && (addr_i == OFF_MOD);
  assign init_wr_o = wr_en_i && (addr_i == OFF_INIT);
  assign unused_ok = wdata_i[5];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q   <= '0;
      clks_q <= CLK_OFF;
      toie_q <= 1'b0;
    end else if (ctrl_wr) begin
      ps_q   <= wdata_i[2:0];
      clks_q <= clk_sel_e'(wdata_i[4:3]);
      toie_q <= wdata_i[6];
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      tof_q <= 1'b0;
    else if (wrap_i)                  tof_q <= 1'b1;
    else if (ctrl_wr && !wdata_i[7])  tof_q <= 1'b0;
  end

  always_comb begin
    unique case (addr_i)
      OFF_CTRL: rd_mux = {{(REG_W-8){1'b0}}, tof_q, toie_q, 1'b0, clks_q, ps_q};
      OFF_CNT:  rd_mux = {{PAD_W{1'b0}}, cnt_i};
      OFF_MOD:  rd_mux = {{PAD_W{1'b0}}, mod_i};
      OFF_INIT: rd_mux = {{PAD_W{1'b0}}, init_i};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign ps_o    = ps_q;
  assign clks_o  = clks_q;
  assign toie_o  = toie_q;
  assign tof_o   = tof_q;
  assign rdata_o = rdata_q;

  assert_tof_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tof_q) |-> $past(wrap_i));
  assert_tof_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tof_q && !ctrl_wr) |=> tof_q);
endmodule

// File: rtl/wrap_timer.sv
module wrap_timer
  import wrap_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              big_endian_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic [REG_W-1:0] wdata_nat, rdata_nat;
  logic [CNT_W-1:0] cnt, mod_v, init_v;
  logic [PS_W-1:0]  ps;
  clk_sel_e         clks;
  logic             toie, tof, run, tick, wrap;
  logic             cnt_wr, mod_wr, init_wr;
  logic             unused_hi;

  assign wdata_nat = big_endian_i ? byte_swap(wdata_i) : wdata_i;
  assign rdata_o   = big_endian_i ? byte_swap(rdata_nat) : rdata_nat;
  assign unused_hi = ^wdata_nat[REG_W-1:CNT_W];
  assign run       = (clks == CLK_SYS);
  assign irq_o     = tof && toie;

  wrap_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_nat[7:0]),
    .cnt_i     (cnt),
    .mod_i     (mod_v),
    .init_i    (init_v),
    .wrap_i    (wrap),
    .ps_o      (ps),
    .clks_o    (clks),
    .toie_o    (toie),
    .tof_o     (tof),
    .cnt_wr_o  (cnt_wr),
    .mod_wr_o  (mod_wr),
    .init_wr_o (init_wr),
    .rdata_o   (rdata_nat)
  );

  wrap_timer_presc u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .ps_i   (ps),
    .tick_o (tick)
  );

  wrap_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .tick_i    (tick),
    .cnt_wr_i  (cnt_wr),
    .mod_wr_i  (mod_wr),
    .init_wr_i (init_wr),
    .wdata_i   (wdata_nat[CNT_W-1:0]),
    .cnt_o     (cnt),
    .mod_o     (mod_v),
    .init_o    (init_v),
    .wrap_o    (wrap)
  );

  assert_irq_needs_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(wrap) || $past(wr_en_i)));
endmodule

// File: tb/sim_wrap_timer.sv
module sim_wrap_timer;
  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        be = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        rd_seen = 1'b0;
  int          checks = 0, fails = 0;
  item_t       sb[$];

  // model of the active state
  logic [15:0] m_cnt = 0, m_mod = 0, m_init = 0;
  logic        m_tof = 0, m_toie = 0;

  always #2 clk = ~clk;

  wrap_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .big_endian_i(be), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] bus(input logic [31:0] v);
    return be ? {v[7:0], v[15:8], v[23:16], v[31:24]} : v;
  endfunction

  function automatic logic [31:0] ctrl(input logic tof, input logic toie,
                                       input logic [1:0] clks, input logic [2:0] ps);
    return {24'h0, tof, toie, 1'b0, clks, ps};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = bus(v);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    sb.push_back('{bus(e), tag});
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq=%b expected %b", tag, irq, e);
    end
  endtask

  // run exactly n (>=2) clocks with clock select 01, then stop
  task automatic run_for(input logic [2:0] ps, input int n);
    wr(8'h00, ctrl(1'b1, m_toie, 2'b01, ps));
    repeat (n - 1) @(posedge clk);
    wr(8'h00, ctrl(1'b1, m_toie, 2'b00, ps));
    for (int i = 0; i < (n >> ps); i++) begin
      if (m_cnt == m_mod) begin m_cnt = m_init; m_tof = 1'b1; end
      else m_cnt = m_cnt + 16'd1;
    end
  endtask

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: compare read results against the scoreboard
  always @(negedge clk) begin
    if (rd_seen) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        fails++;
        $display("FAIL %s: rdata=%h expected %h", it.tag, rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: expired expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(8'h00, 32'h0, "R1");
    rd(8'h04, 32'h0, "R1");
    rd(8'h08, 32'h0, "R1");
    rd(8'h4C, 32'h0, "R1");
    rd(8'h10, 32'h0, "R2");

    // R2/R8 shadow transfer while stopped
    wr(8'h08, 32'd9); m_mod = 9;
    rd(8'h08, 32'd9, "R2");

    // R3 divide by 1
    run_for(3'd0, 7);
    rd(8'h04, {16'h0, m_cnt}, "R3");
    // R4/R5 wrap at MOD to CNTIN
    run_for(3'd0, 5);
    rd(8'h04, {16'h0, m_cnt}, "R4");
    rd(8'h00, ctrl(m_tof, 1'b0, 2'b00, 3'd0), "R5");
    chk_irq(1'b0, "R6");
    m_toie = 1'b1;
    wr(8'h00, ctrl(1'b1, 1'b1, 2'b00, 3'd0));
    chk_irq(1'b1, "R6");
    wr(8'h00, ctrl(1'b0, 1'b1, 2'b00, 3'd0)); m_tof = 1'b0;
    chk_irq(1'b0, "R5");
    wr(8'h00, ctrl(1'b1, 1'b1, 2'b00, 3'd0));
    rd(8'h00, ctrl(1'b0, 1'b1, 2'b00, 3'd0), "R5");

    // R3 prescaled rates
    run_for(3'd2, 11);
    rd(8'h04, {16'h0, m_cnt}, "R3");
    run_for(3'd3, 17);
    rd(8'h04, {16'h0, m_cnt}, "R3");
    // R10 partial intervals discarded
    run_for(3'd2, 3);
    run_for(3'd2, 3);
    rd(8'h04, {16'h0, m_cnt}, "R10");

    // R9 reserved selects stop
    wr(8'h00, ctrl(1'b1, 1'b1, 2'b10, 3'd0));
    repeat (20) @(posedge clk);
    rd(8'h04, {16'h0, m_cnt}, "R9");
    wr(8'h00, ctrl(1'b1, 1'b1, 2'b11, 3'd0));
    repeat (20) @(posedge clk);
    rd(8'h04, {16'h0, m_cnt}, "R9");
    wr(8'h00, ctrl(1'b1, 1'b1, 2'b00, 3'd0));

    // R7 count write reloads CNTIN
    wr(8'h4C, 32'd3); m_init = 3;
    wr(8'h04, 32'h0000BEEF); m_cnt = m_init;
    rd(8'h04, 32'd3, "R7");
    rd(8'h4C, 32'd3, "R8");

    // R8 pending write while running
    wr(8'h00, ctrl(1'b1, 1'b1, 2'b01, 3'd7));
    wr(8'h08, 32'd5);
    rd(8'h08, 32'd9, "R8");
    wr(8'h00, ctrl(1'b1, 1'b1, 2'b00, 3'd7));
    repeat (2) @(posedge clk);
    rd(8'h08, 32'd5, "R8"); m_mod = 5;
    rd(8'h04, {16'h0, m_cnt}, "R9");

    // R4 period MOD-CNTIN+1 with nonzero start
    run_for(3'd0, 8);
    rd(8'h04, {16'h0, m_cnt}, "R4");
    chk_irq(m_tof, "R6");
    wr(8'h00, ctrl(1'b0, 1'b1, 2'b00, 3'd0)); m_tof = 1'b0;

    // R11 big-endian port
    @(negedge clk) be = 1'b1;
    wr(8'h08, 32'd7); m_mod = 7;
    rd(8'h08, 32'd7, "R11");
    rd(8'h00, ctrl(1'b0, 1'b1, 2'b00, 3'd0), "R11");
    run_for(3'd1, 6);
    rd(8'h04, {16'h0, m_cnt}, "R11");
    @(negedge clk) be = 1'b0;
    rd(8'h04, {16'h0, m_cnt}, "R11");

    repeat (4) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule